// File: doc/BRIEF.md
# NOR Flash Command Interface Controller

This block is a synchronous model of the command decoder and program/erase sequencer of a parallel NOR flash whose array is split into equal-sized blocks. Each bus write cycle carries a command byte in the low eight bits of the data word. The controller turns single-cycle and two-cycle command sequences into read-mode changes, word programs, block erases, block protection changes, suspends and resumes. A status register reports readiness, suspension and errors. The array is a small on-chip register file. It comes up fully erased (every bit one). Program and erase durations are counted in clock cycles.

The state machine has these states. `ST_IDLE` waits for a command. `ST_ERS_SETUP`, `ST_PRG_SETUP` and `ST_PROT_SETUP` hold the first cycle of a two-cycle sequence. `ST_ERASING`, `ST_PROGRAMMING` and `ST_PROTECTING` run an operation against the cycle timer. `ST_ERS_SUSP` and `ST_PRG_SUSP` hold a suspended erase or program.

The transitions are as follows:
- From idle, command 20h goes to erase setup, 40h or 10h goes to program setup, and 60h goes to protect setup.
- A setup state always leaves on its next write. It goes to the matching busy state when the confirm cycle is accepted, or back to idle with error bits set when it is not.
- Erasing and programming go to their suspend state on B0h and back to idle when the timer expires.
- Protecting goes back to idle when the timer expires.
- A suspend state goes back to its busy state on D0h.

The read mode (array, status, signature, query) is a separate register. It selects what the read port returns.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array, `rdy` is 1, every array word reads FFFFh, and the status register reads 0080h.
- R2: Command FFh selects array reads, 70h selects status reads, 90h selects signature reads and 98h selects query reads. In signature mode, in-block word offset 0 reads 0020h and offset 1 reads 0016h. In query mode, offsets 0, 1 and 2 read 0051h, 0052h and 0059h.
- R3: Command 40h (or 10h) followed by a write of data D to address A starts a program. `rdy` is low for exactly PROG_CYCLES cycles after the second write. Status reads 0000h while the program runs. Afterwards the word at A holds its old value AND D.
- R4: Command 20h followed by D0h at any address in a block starts an erase. `rdy` is low for exactly ERASE_CYCLES cycles. Reads return status from the confirm cycle on. Afterwards every word of that block reads FFFFh and other blocks are unchanged.
- R5: B0h during an erase suspends it: `rdy` goes 1, status bit 6 goes 1 (status C0h), array reads are allowed, and the block does not change. B0h during a program suspends it with status bit 2 (status 84h). D0h resumes either operation, clears its suspend bit and lets it complete.
- R6: Command 60h followed by 01h at a block address protects that block, taking PROG_CYCLES busy cycles. A program to a protected block sets bits 1 and 4 (0092h). An erase of a protected block sets bits 1 and 5 (00A2h). In both cases the array is unchanged and `rdy` stays 1.
- R7: Command 60h followed by D0h clears the protection of every block.
- R8: A second cycle that is not D0h after 20h, or neither 01h nor D0h after 60h, sets status bits 4 and 5 (00B0h), returns to idle and leaves the array unchanged.
- R9: If `prog_enable_ok` is 0 on a confirm cycle, status bit 3 is set. Bit 4 is also set for program or protect (0098h); bit 5 is set for erase or unprotect (00A8h). No operation starts.
- R10: While any of status bits 5, 4, 3 or 1 is set, a confirm cycle is refused with bits 4 and 5 set and no array change. Command 50h clears those four bits.
- R11: While a protect operation runs, only 70h is acted upon. Other writes such as FFh or B0h are ignored, so reads keep returning status.
- R12: While an erase is suspended, command 20h is ignored: the block is not erased, and status stays C0h until a D0h resumes the suspended erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address: block index in the upper bits, in-block offset in the lower bits |
| bus_wdata | input | DATA_W | Write data; bits 7:0 carry the command code |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | DATA_W | Read data for the current read mode at `bus_addr` |
| prog_enable_ok | input | 1 | Program-enable supply valid |
| rdy | output | 1 | 1 when no operation is running (status bit 7) |

## Verification
Read-mode changes and error bits take effect on the clock edge that captures the write. The bench therefore samples `bus_rdata` on the falling edge right after the write task returns. `bus_rdata` is combinational from the mode, so a changed address is sampled after a short settle delay within the low phase.

For program, erase and protect operations, `rdy` falls on the confirm edge and stays low for exactly the configured number of cycles. The bench counts falling edges with `rdy` low and compares that count with PROG_CYCLES or ERASE_CYCLES. For suspend tests, idle cycles are inserted while suspended to show that the array does not change.

// File: rtl/nor_pkg.sv
package nor_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ERS_SETUP, ST_PRG_SETUP, ST_PROT_SETUP,
        ST_ERASING, ST_PROGRAMMING, ST_PROTECTING,
        ST_ERS_SUSP, ST_PRG_SUSP
    } ctrl_state_t;

    typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_SIGN, RM_QUERY} read_mode_t;

    typedef enum logic [1:0] {OP_PROG, OP_ERASE, OP_PROTECT, OP_UNPROTECT} op_kind_t;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_RD_SIGN   = 8'h90;
    localparam logic [7:0] CMD_RD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
    localparam logic [7:0] CMD_ERASE     = 8'h20;
    localparam logic [7:0] CMD_PROG      = 8'h40;
    localparam logic [7:0] CMD_PROG_ALT  = 8'h10;
    localparam logic [7:0] CMD_PROT      = 8'h60;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] CMD_PROT_SET  = 8'h01;
    localparam logic [7:0] CMD_SUSPEND   = 8'hB0;

    // error vector layout {erase_fail, prog_fail, pen_fail, blk_locked}
    function automatic logic [3:0] confirm_fault(op_kind_t k, logic stale,
                                                 logic pen_ok, logic blk_prot);
        logic ers_side;
        logic [3:0] f;
        ers_side = (k == OP_ERASE) || (k == OP_UNPROTECT);
        f = 4'b0000;
        if (stale)
            f = 4'b1100;
        else if (!pen_ok)
            f = {ers_side, !ers_side, 1'b1, 1'b0};
        else if (blk_prot && (k == OP_PROG || k == OP_ERASE))
            f = {ers_side, !ers_side, 1'b0, 1'b1};
        return f;
    endfunction
endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R5: a paused timer (suspend) keeps its remaining count
    p_timer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
    parameter int NUM_BLOCKS      = 4,
    parameter int WORDS_PER_BLOCK = 8,
    parameter int DATA_W          = 16,
    localparam int OFF_W     = $clog2(WORDS_PER_BLOCK),
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int ADDR_W    = OFF_W + BLK_W,
    localparam int NUM_WORDS = NUM_BLOCKS * WORDS_PER_BLOCK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_prot,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic              prot_set,
    input  logic              prot_clr_all
);
    logic [DATA_W-1:0]     mem [NUM_WORDS];
    logic [NUM_BLOCKS-1:0] prot;
    logic [BLK_W-1:0]      op_blk;

    assign op_blk = op_addr[ADDR_W-1:OFF_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '1;
        end else begin
            if (prog_en) mem[op_addr] <= mem[op_addr] & op_data;
            for (int i = 0; i < NUM_WORDS; i++)
                if (erase_en && (i / WORDS_PER_BLOCK) == int'(op_blk)) mem[i] <= '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            prot <= '0;
        else if (prot_clr_all)
            prot <= '0;
        else if (prot_set)
            prot[op_blk] <= 1'b1;
    end

    assign rd_data  = mem[rd_addr];
    assign chk_prot = prot[chk_addr[ADDR_W-1:OFF_W]];

    // R6: the sequencer never commits a write into a locked block
    p_no_write_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || erase_en) |-> !prot[op_blk]);
    // R3: programming only ever clears bits
    p_prog_clears_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((mem[$past(op_addr)] & ~$past(mem[op_addr])) == '0));
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl import nor_pkg::*; #(
    parameter int NUM_BLOCKS      = 4,
    parameter int WORDS_PER_BLOCK = 8,
    parameter int DATA_W          = 16,
    parameter int PROG_CYCLES     = 4,
    parameter int ERASE_CYCLES    = 8,
    localparam int OFF_W  = $clog2(WORDS_PER_BLOCK),
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int ADDR_W = OFF_W + BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              prog_enable_ok,
    output logic              rdy
);
    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctrl_state_t state, nstate;
    read_mode_t  mode, nmode;
    op_kind_t    op_kind, nop_kind, cf_kind;
    logic [3:0]  err, nerr, fault;   // {sr5, sr4, sr3, sr1}
    logic [ADDR_W-1:0] op_addr, nop_addr;
    logic [DATA_W-1:0] op_data, nop_data, arr_rd;
    logic [7:0]  cmd, sr;
    logic        cf_req, cf_bad, chk_prot, busy_st;
    logic        tmr_load, tmr_tick, tmr_exp;
    logic        prog_en, erase_en, prot_set, prot_clr_all;
    logic [CNT_W-1:0] tmr_len;

    assign cmd     = bus_wdata[7:0];
    assign busy_st = (state == ST_ERASING) || (state == ST_PROGRAMMING) || (state == ST_PROTECTING);

    nor_cell_array #(.NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK),
                     .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(bus_addr), .rd_data(arr_rd),
        .chk_addr(bus_addr), .chk_prot(chk_prot), .op_addr(op_addr), .op_data(op_data),
        .prog_en(prog_en), .erase_en(erase_en), .prot_set(prot_set),
        .prot_clr_all(prot_clr_all));

    nor_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_len),
        .tick(tmr_tick), .expired(tmr_exp));

    // classify the second cycle of a two-cycle sequence
    always_comb begin
        cf_req  = 1'b0;
        cf_bad  = 1'b0;
        cf_kind = OP_PROG;
        if (bus_we) begin
            unique case (state)
                ST_ERS_SETUP: begin
                    cf_req = 1'b1; cf_kind = OP_ERASE; cf_bad = (cmd != CMD_CONFIRM);
                end
                ST_PRG_SETUP: begin
                    cf_req = 1'b1; cf_kind = OP_PROG;
                end
                ST_PROT_SETUP: begin
                    cf_req  = 1'b1;
                    cf_kind = (cmd == CMD_CONFIRM) ? OP_UNPROTECT : OP_PROTECT;
                    cf_bad  = (cmd != CMD_CONFIRM) && (cmd != CMD_PROT_SET);
                end
                default: ;
            endcase
        end
        fault = confirm_fault(cf_kind, |err, prog_enable_ok, chk_prot);
    end

    // next-state and control decode
    always_comb begin
        nstate = state; nmode = mode; nerr = err;
        nop_kind = op_kind; nop_addr = op_addr; nop_data = op_data;
        tmr_load = 1'b0; tmr_tick = 1'b0; tmr_len = '0;
        prog_en = 1'b0; erase_en = 1'b0; prot_set = 1'b0; prot_clr_all = 1'b0;
        unique case (state)
            ST_IDLE, ST_ERS_SUSP, ST_PRG_SUSP: if (bus_we) begin
                unique case (cmd)
                    CMD_RD_ARRAY:  nmode = RM_ARRAY;
                    CMD_RD_STATUS: nmode = RM_STATUS;
                    CMD_RD_SIGN:   nmode = RM_SIGN;
                    CMD_RD_QUERY:  nmode = RM_QUERY;
                    CMD_CLR_STAT:  nerr  = 4'b0000;
                    CMD_ERASE: if (state == ST_IDLE) begin
                        nstate = ST_ERS_SETUP; nmode = RM_STATUS;
                    end
                    CMD_PROG, CMD_PROG_ALT: if (state == ST_IDLE) begin
                        nstate = ST_PRG_SETUP; nmode = RM_STATUS;
                    end
                    CMD_PROT: if (state == ST_IDLE) begin
                        nstate = ST_PROT_SETUP; nmode = RM_STATUS;
                    end
                    CMD_CONFIRM: if (state != ST_IDLE) begin
                        nstate = (state == ST_ERS_SUSP) ? ST_ERASING : ST_PROGRAMMING;
                        nmode  = RM_STATUS;
                    end
                    default: ;
                endcase
            end
            ST_ERS_SETUP, ST_PRG_SETUP, ST_PROT_SETUP: if (cf_req) begin
                nstate = ST_IDLE;
                nmode  = RM_STATUS;
                if (cf_bad)
                    nerr = err | 4'b1100;
                else if (fault != 4'b0000)
                    nerr = err | fault;
                else begin
                    nop_kind = cf_kind; nop_addr = bus_addr; nop_data = bus_wdata;
                    tmr_load = 1'b1;
                    unique case (cf_kind)
                        OP_PROG:  begin nstate = ST_PROGRAMMING; tmr_len = CNT_W'(PROG_CYCLES - 1); end
                        OP_ERASE: begin nstate = ST_ERASING;     tmr_len = CNT_W'(ERASE_CYCLES - 1); end
                        default:  begin nstate = ST_PROTECTING;  tmr_len = CNT_W'(PROG_CYCLES - 1); end
                    endcase
                end
            end
            ST_ERASING, ST_PROGRAMMING: begin
                if (bus_we && cmd == CMD_RD_STATUS) nmode = RM_STATUS;
                if (tmr_exp) begin
                    prog_en  = (state == ST_PROGRAMMING);
                    erase_en = (state == ST_ERASING);
                    nstate   = ST_IDLE;
                end else if (bus_we && cmd == CMD_SUSPEND) begin
                    nstate = (state == ST_ERASING) ? ST_ERS_SUSP : ST_PRG_SUSP;
                    nmode  = RM_STATUS;
                end else
                    tmr_tick = 1'b1;
            end
            ST_PROTECTING: begin
                if (bus_we && cmd == CMD_RD_STATUS) nmode = RM_STATUS;
                if (tmr_exp) begin
                    prot_set     = (op_kind == OP_PROTECT);
                    prot_clr_all = (op_kind == OP_UNPROTECT);
                    nstate       = ST_IDLE;
                end else
                    tmr_tick = 1'b1;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode    <= RM_ARRAY;
            err     <= 4'b0000;
            op_kind <= OP_PROG;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            state   <= nstate;
            mode    <= nmode;
            err     <= nerr;
            op_kind <= nop_kind;
            op_addr <= nop_addr;
            op_data <= nop_data;
        end
    end

    // outputs
    always_comb begin
        rdy = !busy_st;
        sr  = {rdy, state == ST_ERS_SUSP, err[3], err[2], err[1],
               state == ST_PRG_SUSP, err[0], 1'b0};
        bus_rdata = '0;
        unique case (mode)
            RM_ARRAY:  bus_rdata = arr_rd;
            RM_STATUS: bus_rdata = DATA_W'(sr);
            RM_SIGN: begin
                if (bus_addr[OFF_W-1:0] == OFF_W'(0))      bus_rdata = DATA_W'(16'h0020);
                else if (bus_addr[OFF_W-1:0] == OFF_W'(1)) bus_rdata = DATA_W'(16'h0016);
            end
            RM_QUERY: begin
                if (bus_addr[OFF_W-1:0] == OFF_W'(0))      bus_rdata = DATA_W'(16'h0051);
                else if (bus_addr[OFF_W-1:0] == OFF_W'(1)) bus_rdata = DATA_W'(16'h0052);
                else if (bus_addr[OFF_W-1:0] == OFF_W'(2)) bus_rdata = DATA_W'(16'h0059);
            end
        endcase
    end

    // R11: non-status writes during a protect leave the read mode alone
    p_protect_locks_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROTECTING && bus_we && cmd != CMD_RD_STATUS) |=> (mode == $past(mode)));
    // R10: a confirm with stale errors never starts an operation
    p_stale_err_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_req && err != 4'b0000) |=> rdy);
    // R3: a clean program confirm drops rdy on the next cycle
    p_prog_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRG_SETUP && bus_we && err == 4'b0000 && prog_enable_ok && !chk_prot)
        |=> !rdy);
    // R5: resuming a suspended erase returns to the busy erase state
    p_resume_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERS_SUSP && bus_we && cmd == CMD_CONFIRM) |=> (state == ST_ERASING && !rdy));
endmodule

// File: tb/nor_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module nor_cmd_ctrl_tb_top;
    localparam int PROG_N  = 5;
    localparam int ERASE_N = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        prog_enable_ok = 1'b1;
    logic        rdy;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    nor_cmd_ctrl #(.NUM_BLOCKS(4), .WORDS_PER_BLOCK(8), .DATA_W(16),
                   .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .prog_enable_ok(prog_enable_ok), .rdy(rdy));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %04h expected %04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!rdy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(5'd0, d);  chk("R1 array word after reset", d, 16'hFFFF);
        rd(5'd31, d); chk("R1 last word after reset", d, 16'hFFFF);
        chk("R1 rdy after reset", {15'd0, rdy}, 16'h0001);
        wr(5'd0, 16'h0070); rd(5'd0, d); chk("R1 status after reset", d, 16'h0080);
    endtask

    task automatic t_read_modes;
        logic [15:0] d;
        wr(5'd0, 16'h0090);
        rd(5'd8, d); chk("R2 signature offset 0", d, 16'h0020);
        rd(5'd9, d); chk("R2 signature offset 1", d, 16'h0016);
        wr(5'd0, 16'h0098);
        rd(5'd0, d); chk("R2 query offset 0", d, 16'h0051);
        rd(5'd2, d); chk("R2 query offset 2", d, 16'h0059);
        wr(5'd0, 16'h0070); rd(5'd0, d); chk("R2 status mode", d, 16'h0080);
        wr(5'd0, 16'h00FF); rd(5'd5, d); chk("R2 array mode", d, 16'hFFFF);
    endtask

    task automatic do_prog(input string req, input logic [4:0] a, input logic [15:0] v);
        logic [15:0] d;
        int n;
        wr(a, 16'h0040);
        wr(a, v);
        rd(a, d); chk({req, " status while programming"}, d, 16'h0000);
        wait_rdy(n);
        chk({req, " program busy cycles"}, 16'(n), 16'(PROG_N));
    endtask

    task automatic t_program;
        logic [15:0] d;
        do_prog("R3", 5'd5, 16'h12F0);
        rd(5'd5, d); chk("R3 status after program", d, 16'h0080);
        wr(5'd0, 16'h00FF); rd(5'd5, d); chk("R3 programmed word", d, 16'h12F0);
        do_prog("R3", 5'd5, 16'hFF0F);
        wr(5'd0, 16'h00FF); rd(5'd5, d); chk("R3 program ANDs old data", d, 16'h1200);
    endtask

    task automatic t_erase;
        logic [15:0] d;
        int n;
        do_prog("R4", 5'd9, 16'h0000);
        wr(5'd10, 16'h0020);
        wr(5'd10, 16'h00D0);
        rd(5'd10, d); chk("R4 reads return status during erase", d, 16'h0000);
        wait_rdy(n);
        chk("R4 erase busy cycles", 16'(n), 16'(ERASE_N));
        wr(5'd0, 16'h00FF);
        rd(5'd9, d); chk("R4 erased block word", d, 16'hFFFF);
        rd(5'd5, d); chk("R4 other block unchanged", d, 16'h1200);
    endtask

    task automatic t_suspend;
        logic [15:0] d;
        int n;
        wr(5'd0, 16'h0020);
        wr(5'd0, 16'h00D0);
        idle(2);
        wr(5'd0, 16'h00B0);
        rd(5'd0, d); chk("R5 erase suspended status", d, 16'h00C0);
        wr(5'd0, 16'h00FF);
        idle(ERASE_N + 4);
        rd(5'd5, d); chk("R5 block untouched while suspended", d, 16'h1200);
        wr(5'd0, 16'h00D0);
        rd(5'd0, d); chk("R5 resume clears suspend bit", d, 16'h0000);
        wait_rdy(n);
        rd(5'd0, d); chk("R5 status after resumed erase", d, 16'h0080);
        wr(5'd0, 16'h00FF); rd(5'd5, d); chk("R5 resumed erase completed", d, 16'hFFFF);
        wr(5'd6, 16'h0040);
        wr(5'd6, 16'h00FF);
        wr(5'd6, 16'h00B0);
        rd(5'd6, d); chk("R5 program suspended status", d, 16'h0084);
        wr(5'd6, 16'h00D0);
        wait_rdy(n);
        wr(5'd0, 16'h00FF); rd(5'd6, d); chk("R5 resumed program completed", d, 16'h00FF);
    endtask

    task automatic t_protect;
        logic [15:0] d;
        int n;
        wr(5'd16, 16'h0060);
        wr(5'd16, 16'h0001);
        wait_rdy(n);
        chk("R6 protect busy cycles", 16'(n), 16'(PROG_N));
        wr(5'd17, 16'h0040);
        wr(5'd17, 16'h0000);
        rd(5'd17, d); chk("R6 program to locked block", d, 16'h0092);
        wr(5'd0, 16'h0050);
        wr(5'd16, 16'h0020);
        wr(5'd16, 16'h00D0);
        rd(5'd16, d); chk("R6 erase of locked block", d, 16'h00A2);
        wr(5'd0, 16'h0050);
        wr(5'd0, 16'h00FF); rd(5'd17, d); chk("R6 locked word unchanged", d, 16'hFFFF);
        do_prog("R6", 5'd24, 16'h0F0F);
        wr(5'd0, 16'h00FF); rd(5'd24, d); chk("R6 unlocked block programs", d, 16'h0F0F);
    endtask

    task automatic t_unprotect;
        logic [15:0] d;
        int n;
        wr(5'd0, 16'h0060);
        wr(5'd0, 16'h00D0);
        wait_rdy(n);
        do_prog("R7", 5'd17, 16'h00F0);
        wr(5'd0, 16'h00FF); rd(5'd17, d); chk("R7 program after unprotect", d, 16'h00F0);
    endtask

    task automatic t_bad_sequence;
        logic [15:0] d;
        wr(5'd24, 16'h0020);
        wr(5'd24, 16'h0055);
        rd(5'd24, d); chk("R8 bad erase confirm", d, 16'h00B0);
        wr(5'd0, 16'h0050);
        wr(5'd24, 16'h0060);
        wr(5'd24, 16'h0033);
        rd(5'd24, d); chk("R8 bad protect confirm", d, 16'h00B0);
        wr(5'd0, 16'h0050);
        wr(5'd0, 16'h00FF); rd(5'd24, d); chk("R8 array unchanged", d, 16'h0F0F);
    endtask

    task automatic t_pen_low;
        logic [15:0] d;
        prog_enable_ok = 1'b0;
        wr(5'd25, 16'h0040);
        wr(5'd25, 16'h0000);
        rd(5'd25, d); chk("R9 program with enable low", d, 16'h0098);
        wr(5'd0, 16'h0050);
        wr(5'd24, 16'h0020);
        wr(5'd24, 16'h00D0);
        rd(5'd24, d); chk("R9 erase with enable low", d, 16'h00A8);
        wr(5'd0, 16'h0050);
        prog_enable_ok = 1'b1;
        wr(5'd0, 16'h00FF);
        rd(5'd24, d); chk("R9 erase target unchanged", d, 16'h0F0F);
        rd(5'd25, d); chk("R9 program target unchanged", d, 16'hFFFF);
    endtask

    task automatic t_stale;
        logic [15:0] d;
        wr(5'd0, 16'h0020);
        wr(5'd0, 16'h0077);
        wr(5'd26, 16'h0040);
        wr(5'd26, 16'h0000);
        rd(5'd26, d); chk("R10 confirm refused with stale errors", d, 16'h00B0);
        chk("R10 rdy stays high", {15'd0, rdy}, 16'h0001);
        wr(5'd0, 16'h00FF); rd(5'd26, d); chk("R10 array unchanged", d, 16'hFFFF);
        wr(5'd0, 16'h0050);
        wr(5'd0, 16'h0070); rd(5'd0, d); chk("R10 clear status", d, 16'h0080);
        do_prog("R10", 5'd26, 16'h1234);
        wr(5'd0, 16'h00FF); rd(5'd26, d); chk("R10 program after clear", d, 16'h1234);
    endtask

    task automatic t_protect_busy;
        logic [15:0] d;
        int n;
        wr(5'd0, 16'h0060);
        wr(5'd0, 16'h0001);
        wr(5'd0, 16'h00FF);
        rd(5'd0, d); chk("R11 FFh ignored during protect", d, 16'h0000);
        wr(5'd0, 16'h00B0);
        rd(5'd0, d); chk("R11 B0h ignored during protect", d, 16'h0000);
        wait_rdy(n);
        rd(5'd0, d); chk("R11 still status after protect", d, 16'h0080);
    endtask

    task automatic t_erase_in_suspend;
        logic [15:0] d;
        int n;
        wr(5'd24, 16'h0020);
        wr(5'd24, 16'h00D0);
        idle(1);
        wr(5'd24, 16'h00B0);
        wr(5'd24, 16'h0020);
        rd(5'd24, d); chk("R12 20h ignored while erase suspended", d, 16'h00C0);
        wr(5'd0, 16'h00FF); rd(5'd24, d); chk("R12 block not erased yet", d, 16'h0F0F);
        wr(5'd24, 16'h00D0);
        rd(5'd24, d); chk("R12 D0h resumes erase", d, 16'h0000);
        wait_rdy(n);
        wr(5'd0, 16'h00FF); rd(5'd24, d); chk("R12 resumed erase done", d, 16'hFFFF);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_modes();
        t_program();
        t_erase();
        t_suspend();
        t_protect();
        t_unprotect();
        t_bad_sequence();
        t_pen_low();
        t_stale();
        t_protect_busy();
        t_erase_in_suspend();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule